// File: doc/BRIEF.md
# Dual-Core Message Mailbox

This block passes 32-bit messages between two processor cores through two independent one-way queues. One queue is filled by core 0 and emptied by core 1. The other is filled by core 1 and emptied by core 0. Each core sees the same view: a transmit strobe with data, a receive strobe, a four-bit status word and an interrupt line. Internally the transmit and receive sides are cross-wired, so a word that one core pushes is popped by the other core.

Illegal accesses are refused and recorded. A push into a full queue is dropped. A pop from an empty queue is dropped and returns zero. Each kind of refusal sets a sticky flag in the status of the core that made the access. The flags stay set until that core strobes its status-clear input. A core's interrupt is asserted while its receive queue holds a word or while either of its sticky flags is set.

Top module: `ipc_mailbox`

## Requirements
- R1: Each direction holds up to DEPTH (default 8) words of DATA_W (default 32) bits. The word that would be the ninth is refused.
- R2: A word pushed by core 0 is popped only by core 1. A word pushed by core 1 is popped only by core 0. A core never sees its own words.
- R3: Each pop strobe removes exactly one word, in arrival order. The word appears on that core's read data in the cycle after the strobe and holds until the next pop strobe.
- R4: Status bit 1 is 1 while the core's transmit queue is not full. A push while that queue is full leaves the queue contents unchanged and sets status bit 2.
- R5: Status bit 0 is 1 while the core's receive queue is not empty. A pop while that queue is empty returns zero, leaves the queue unchanged and sets status bit 3.
- R6: A status-clear strobe clears status bits 3:2 of that core in the next cycle. If a new error happens in the same cycle as the clear, the error wins and its flag stays set.
- R7: The sticky flags are kept separately for each core. Only a core's own accesses set its flags, and only its own clear strobe clears them.
- R8: A core's interrupt is 1 exactly when its status bit 0, bit 2 or bit 3 is 1.
- R9: A push and a pop on the same queue in one cycle are both performed when both are legal. Legality is judged on the queue state before that cycle: on a full queue the pop is performed and the push is dropped, and on an empty queue the push is performed and the pop is dropped.
- R10: After synchronous active-low reset both queues are empty, all sticky flags are 0, both status words read 4'b0010 and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| c0_tx_we | input | 1 | Core 0 push strobe |
| c0_tx_data | input | DATA_W | Core 0 push data |
| c0_rx_re | input | 1 | Core 0 pop strobe |
| c0_rx_data | output | DATA_W | Core 0 popped word |
| c0_st_clr | input | 1 | Core 0 sticky-flag clear strobe |
| c0_status | output | 4 | Core 0 status: {rd_err, wr_err, tx_ready, rx_valid} |
| c0_irq | output | 1 | Core 0 interrupt |
| c1_tx_we | input | 1 | Core 1 push strobe |
| c1_tx_data | input | DATA_W | Core 1 push data |
| c1_rx_re | input | 1 | Core 1 pop strobe |
| c1_rx_data | output | DATA_W | Core 1 popped word |
| c1_st_clr | input | 1 | Core 1 sticky-flag clear strobe |
| c1_status | output | 4 | Core 1 status: {rd_err, wr_err, tx_ready, rx_valid} |
| c1_irq | output | 1 | Core 1 interrupt |

## Verification
The assertions assume that each strobe is a clean level sampled at the rising edge and that a clear strobe may coincide with any access. They do not assume that software checks the status before it pushes or pops. The bench therefore deliberately pushes into full queues, pops from empty ones, and issues clears in the same cycle as errors. It changes every input only at falling edges, so each strobe is stable for one whole cycle.

// File: rtl/ipc_mailbox_pkg.sv
// Package: shared constants for the mailbox.
// Assumes: the status word layout is fixed, because software decodes it.
package ipc_mailbox_pkg;
    localparam int ST_W        = 4;
    localparam int ST_RX_VALID = 0;
    localparam int ST_TX_READY = 1;
    localparam int ST_WR_ERR   = 2;
    localparam int ST_RD_ERR   = 3;
    localparam int NUM_CORES   = 2;
endpackage

// File: rtl/ipc_fifo.sv
// Module: one-way word queue that refuses illegal accesses.
// Pushes into a full queue and pops from an empty one are dropped and flagged.
// Legality is judged on the state before the cycle.
// Assumes: DEPTH >= 2. Read data is registered and updates only on a pop strobe.
module ipc_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              not_empty,
    output logic              not_full,
    output logic              wr_drop,
    output logic              rd_drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              wr_ok, rd_ok;

    // Decode legality of this cycle's accesses.
    always_comb begin
        not_empty = (count != '0);
        not_full  = (count != CW'(DEPTH));
        wr_ok     = wr_en && not_full;
        rd_ok     = rd_en && not_empty;
        wr_drop   = wr_en && !not_full;
        rd_drop   = rd_en && !not_empty;
    end

    // Storage write. Storage is not reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Pointers, occupancy and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (wr_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !wr_ok) count <= count - 1'b1;
            if (rd_en) rd_data <= rd_ok ? mem[rd_ptr] : '0;
        end
    end

    // R1: occupancy never exceeds the depth.
    assert_count_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4: a lone push into a full queue leaves it full.
    assert_full_push_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !not_full && !rd_en) |=> !not_full);

    // R5: a lone pop from an empty queue returns zero and leaves the queue empty.
    assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !not_empty && !wr_en) |=> (!not_empty && rd_data == '0));

    // R9: a legal push and pop together keep the occupancy.
    assert_push_pop_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && not_empty && not_full) |=> $stable(count));
endmodule

// File: rtl/ipc_status_port.sv
// Module: one core's status view, sticky error flags and interrupt.
// Assumes: the error pulses come from this core's own accesses only.
// An error in the same cycle as a clear wins.
module ipc_status_port
    import ipc_mailbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_clr,
    input  logic            rx_not_empty,
    input  logic            tx_not_full,
    input  logic            tx_drop,
    input  logic            rx_drop,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    logic wr_err_q, rd_err_q;

    // Sticky flags: set by errors, cleared by a status-clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err_q <= 1'b0;
            rd_err_q <= 1'b0;
        end else begin
            wr_err_q <= tx_drop || (wr_err_q && !st_clr);
            rd_err_q <= rx_drop || (rd_err_q && !st_clr);
        end
    end

    // Assemble the status word and the interrupt.
    always_comb begin
        status              = '0;
        status[ST_RX_VALID] = rx_not_empty;
        status[ST_TX_READY] = tx_not_full;
        status[ST_WR_ERR]   = wr_err_q;
        status[ST_RD_ERR]   = rd_err_q;
        irq                 = rx_not_empty || wr_err_q || rd_err_q;
    end

    // R6: a clear with no concurrent error empties the sticky flags.
    assert_clear_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_clr && !tx_drop && !rx_drop) |=> (status[ST_RD_ERR:ST_WR_ERR] == 2'b00));

    // R8: a dropped access raises the interrupt in the next cycle.
    assert_drop_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_drop || rx_drop) |=> irq);

    // R7: without a clear, a set flag stays set.
    assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_clr && status[ST_WR_ERR]) |=> status[ST_WR_ERR]);
endmodule

// File: rtl/ipc_mailbox.sv
// Module: two-core mailbox top. Holds one queue per direction.
// Each core's push and pop ports are cross-wired to the right queue.
// Assumes: core k's push side feeds queue k, and core k pops from queue 1-k.
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_tx_we,
    input  logic [DATA_W-1:0] c0_tx_data,
    input  logic              c0_rx_re,
    output logic [DATA_W-1:0] c0_rx_data,
    input  logic              c0_st_clr,
    output logic [ST_W-1:0]   c0_status,
    output logic              c0_irq,
    input  logic              c1_tx_we,
    input  logic [DATA_W-1:0] c1_tx_data,
    input  logic              c1_rx_re,
    output logic [DATA_W-1:0] c1_rx_data,
    input  logic              c1_st_clr,
    output logic [ST_W-1:0]   c1_status,
    output logic              c1_irq
);
    logic              we    [NUM_CORES];
    logic [DATA_W-1:0] wdata [NUM_CORES];
    logic              re    [NUM_CORES];
    logic              clr   [NUM_CORES];
    logic [DATA_W-1:0] q_rd  [NUM_CORES];
    logic              q_ne  [NUM_CORES];
    logic              q_nf  [NUM_CORES];
    logic              q_wd  [NUM_CORES];
    logic              q_rdd [NUM_CORES];
    logic [ST_W-1:0]   st    [NUM_CORES];
    logic              irq_v [NUM_CORES];

    // Gather the per-core ports into arrays.
    always_comb begin
        we[0] = c0_tx_we;  wdata[0] = c0_tx_data;  re[0] = c0_rx_re;  clr[0] = c0_st_clr;
        we[1] = c1_tx_we;  wdata[1] = c1_tx_data;  re[1] = c1_rx_re;  clr[1] = c1_st_clr;
    end

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        localparam int PEER = NUM_CORES - 1 - k;

        // Queue k: written by core k, read by the peer core.
        ipc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (we[k]),
            .wr_data   (wdata[k]),
            .rd_en     (re[PEER]),
            .rd_data   (q_rd[k]),
            .not_empty (q_ne[k]),
            .not_full  (q_nf[k]),
            .wr_drop   (q_wd[k]),
            .rd_drop   (q_rdd[k])
        );

        // Core k's view: transmit is queue k, receive is queue PEER.
        ipc_status_port u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .st_clr       (clr[k]),
            .rx_not_empty (q_ne[PEER]),
            .tx_not_full  (q_nf[k]),
            .tx_drop      (q_wd[k]),
            .rx_drop      (q_rdd[PEER]),
            .status       (st[k]),
            .irq          (irq_v[k])
        );
    end

    // Drive the per-core outputs: each core reads its peer's queue.
    always_comb begin
        c0_rx_data = q_rd[1];  c0_status = st[0];  c0_irq = irq_v[0];
        c1_rx_data = q_rd[0];  c1_status = st[1];  c1_irq = irq_v[1];
    end

    // R2: a push by core 0 into an empty queue becomes visible to core 1 only.
    assert_cross_wiring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_tx_we && !c0_status[ST_TX_READY] == 1'b0 && !c1_status[ST_RX_VALID] && !c1_rx_re)
        |=> c1_status[ST_RX_VALID]);
endmodule

// File: tb/test_ipc_mailbox.sv
// Directed bench for ipc_mailbox. Inputs change at falling edges and
// outputs are sampled at the falling edge after each active edge.
module test_ipc_mailbox;
    localparam int DW = 32;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          c0_tx_we = 0, c0_rx_re = 0, c0_st_clr = 0;
    logic          c1_tx_we = 0, c1_rx_re = 0, c1_st_clr = 0;
    logic [DW-1:0] c0_tx_data = '0, c1_tx_data = '0;
    logic [DW-1:0] c0_rx_data, c1_rx_data;
    logic [3:0]    c0_status, c1_status;
    logic          c0_irq, c1_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ipc_mailbox #(.DATA_W(DW), .DEPTH(DP)) i_ipc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .c0_tx_we(c0_tx_we), .c0_tx_data(c0_tx_data), .c0_rx_re(c0_rx_re),
        .c0_rx_data(c0_rx_data), .c0_st_clr(c0_st_clr), .c0_status(c0_status), .c0_irq(c0_irq),
        .c1_tx_we(c1_tx_we), .c1_tx_data(c1_tx_data), .c1_rx_re(c1_rx_re),
        .c1_rx_data(c1_rx_data), .c1_st_clr(c1_st_clr), .c1_status(c1_status), .c1_irq(c1_irq)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, then sample at the next falling edge.
    task automatic cyc(input logic w0, input logic [DW-1:0] d0, input logic r0, input logic s0,
                       input logic w1, input logic [DW-1:0] d1, input logic r1, input logic s1);
        c0_tx_we = w0; c0_tx_data = d0; c0_rx_re = r0; c0_st_clr = s0;
        c1_tx_we = w1; c1_tx_data = d1; c1_rx_re = r1; c1_st_clr = s1;
        @(negedge clk);
        c0_tx_we = 0; c0_rx_re = 0; c0_st_clr = 0;
        c1_tx_we = 0; c1_rx_re = 0; c1_st_clr = 0;
    endtask

    task automatic t_reset();
        chk("R10 c0 status", 32'(c0_status), 32'h2);
        chk("R10 c1 status", 32'(c1_status), 32'h2);
        chk("R10 irqs", 32'({c0_irq, c1_irq}), 32'h0);
    endtask

    task automatic t_c0_to_c1();
        for (int i = 0; i < 3; i++) cyc(1, 32'hA000_0000 + i, 0, 0, 0, 0, 0, 0);
        chk("R2 c1 rx valid", 32'(c1_status), 32'h3);
        chk("R2 c0 no own words", 32'(c0_status), 32'h2);
        chk("R8 c1 irq on data", 32'(c1_irq), 32'h1);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 1, 0);
            chk("R3 order c0->c1", c1_rx_data, 32'hA000_0000 + i);
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 data holds", c1_rx_data, 32'hA000_0002);
        chk("R5 c1 drained", 32'(c1_status), 32'h2);
        chk("R8 c1 irq low", 32'(c1_irq), 32'h0);
    endtask

    task automatic t_c1_to_c0();
        cyc(0, 0, 0, 0, 1, 32'h5555_1234, 0, 0);
        cyc(0, 0, 0, 0, 1, 32'hDEAD_BEEF, 0, 0);
        chk("R2 c0 rx valid", 32'(c0_status), 32'h3);
        cyc(0, 0, 1, 0, 0, 0, 0, 0);
        chk("R3 c1->c0 first", c0_rx_data, 32'h5555_1234);
        cyc(0, 0, 1, 0, 0, 0, 0, 0);
        chk("R3 c1->c0 second", c0_rx_data, 32'hDEAD_BEEF);
        chk("R2 c0 empty", 32'(c0_status), 32'h2);
    endtask

    task automatic t_overflow_underflow();
        for (int i = 0; i < DP; i++) cyc(1, 32'h100 + i, 0, 0, 0, 0, 0, 0);
        chk("R4 full tx not ready", 32'(c0_status), 32'h0);
        cyc(1, 32'hBAD0_BAD0, 0, 0, 0, 0, 0, 0);
        chk("R4 wr err set", 32'(c0_status), 32'h4);
        chk("R8 c0 irq on err", 32'(c0_irq), 32'h1);
        chk("R7 c1 flags clean", 32'(c1_status), 32'h3);
        for (int i = 0; i < DP; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 1, 0);
            chk("R1 drain order", c1_rx_data, 32'h100 + i);
        end
        chk("R1 ninth refused", 32'(c1_status), 32'h2);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R5 empty pop zero", c1_rx_data, 32'h0);
        chk("R5 rd err set", 32'(c1_status), 32'hA);
        chk("R7 c0 keeps own only", 32'(c0_status), 32'h6);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R6 c0 cleared", 32'(c0_status), 32'h2);
        chk("R6 c0 irq low", 32'(c0_irq), 32'h0);
        chk("R7 c1 untouched", 32'(c1_status), 32'hA);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R6 c1 cleared", 32'(c1_status), 32'h2);
    endtask

    task automatic t_simultaneous();
        cyc(1, 32'h11, 0, 0, 0, 0, 0, 0);
        cyc(1, 32'h22, 0, 0, 0, 0, 1, 0);
        chk("R9 pop during push", c1_rx_data, 32'h11);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R9 pushed word kept", c1_rx_data, 32'h22);
        for (int i = 0; i < DP; i++) cyc(1, 32'h300 + i, 0, 0, 0, 0, 0, 0);
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 0);
        chk("R9 full: pop done", c1_rx_data, 32'h300);
        chk("R9 full: push dropped", 32'(c0_status), 32'h6);
        for (int i = 1; i < DP; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 1, 0);
            chk("R9 full: order", c1_rx_data, 32'h300 + i);
        end
        chk("R9 full: nothing extra", 32'(c1_status), 32'h2);
        cyc(1, 32'h77, 0, 1, 0, 0, 1, 0);
        chk("R9 empty: pop zero", c1_rx_data, 32'h0);
        chk("R9 empty: rd err", 32'(c1_status), 32'hB);
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R9 empty: push kept", c1_rx_data, 32'h77);
        chk("R6 c1 cleared", 32'(c1_status), 32'h2);
    endtask

    task automatic t_clear_race();
        cyc(0, 0, 1, 1, 0, 0, 0, 0);
        chk("R6 error beats clear", 32'(c0_status), 32'hA);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R6 later clear", 32'(c0_status), 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_c0_to_c1();
        t_c1_to_c0();
        t_overflow_underflow();
        t_simultaneous();
        t_clear_race();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule